// File: doc/BRIEF.md
# Watchdog Frequency Self-Recovery Controller

This block guards software-driven changes to a clock synthesizer's output frequency. Software commits a new operating point either by writing a frequency-select code or by loading a divider pair. If a non-zero watchdog period, in whole seconds, has been programmed beforehand, that commit starts a timer that counts a millisecond tick. Software confirms that the system survived the change by writing the period back to zero. When no such confirmation arrives in time, the block restores a known-safe frequency code, raises a sticky timeout flag and holds the system reset line low for a fixed number of milliseconds.

The safe code depends on a policy bit. With the bit clear, the block falls back to the strap code latched by hardware. With it set, the block returns to the software code that was in force before the commit that triggered the timeout. To supply that code, the block keeps a history of the last two committed software codes. Divider pairs are range-checked before they are accepted. The active pair is the stored one while divider mode is on, and a built-in default pair otherwise.

Top module: `wdfr_ctrl`

## Requirements
- R1: Once reset is released, `act_fs` equals `hw_fs`, `wd_timeout` is 0, `sys_rst_n` is 1, and with `div_en` low `act_m`/`act_n` show the defaults (M_DEFAULT, N_DEFAULT).
- R2: A pulse on `sw_fs_wr` is a commit, whatever the code. In the next cycle, `act_fs` equals the written `sw_fs_code`.
- R3: A commit made while the stored period P is non-zero arms the timer. Expiry follows the P×TICKS_PER_SEC-th `tick_ms` pulse after the commit, and no earlier tick causes it.
- R4: A commit made while the stored period is 0 does not arm the timer. No number of ticks then produces a timeout or a reset pulse.
- R5: A write of period 0 before expiry stops the timer. The committed code stays on `act_fs` and no reset pulse follows.
- R6: On expiry, `wd_timeout` becomes 1 and `sys_rst_n` goes low in the next cycle. It stays low for exactly RST_TICKS further `tick_ms` pulses, then returns to 1.
- R7: On expiry with the stored revert bit at 0, `act_fs` becomes `hw_fs`.
- R8: On expiry with the revert bit at 1, `act_fs` becomes the software code committed just before the most recent software commit.
- R9: A watchdog write with period 0 clears `wd_timeout` in the next cycle.
- R10: A divider write is stored only when 20 ≤ M ≤ 58, 21 ≤ N ≤ 125, N > M and 2·M > N (bounds inclusive). `act_m`/`act_n` show the stored pair while `div_en` is 1 and the defaults while it is 0.
- R11: A divider write that fails the range test leaves the stored pair unchanged and does not arm the timer.
- R12: An accepted divider write is a commit. It arms the timer in the same way as R3.
- R13: A commit while the timer runs restarts the count from zero. Expiry then takes a full period measured from the latest commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| hw_fs | input | FS_W | Strap-latched frequency code |
| sw_fs_wr | input | 1 | Software frequency code write strobe |
| sw_fs_code | input | FS_W | Software frequency code |
| wd_wr | input | 1 | Watchdog control write strobe |
| wd_period | input | WD_W | Period in seconds, 0 = off / clear |
| wd_revert | input | 1 | Revert policy: 0 strap, 1 prior software code |
| div_wr | input | 1 | Divider pair write strobe |
| div_m | input | M_W | Divider M value |
| div_n | input | N_W | Divider N value |
| div_en | input | 1 | Divider mode enable |
| act_fs | output | FS_W | Active frequency code |
| act_m | output | M_W | Active divider M |
| act_n | output | N_W | Active divider N |
| wd_timeout | output | 1 | Sticky watchdog timeout flag |
| sys_rst_n | output | 1 | Active-low system reset pulse |

## Verification
The bench counts ticks up to one short of the armed period and confirms that nothing has happened yet. A design whose comparison is off by one tick would pulse too early or too late. It recommits partway through a period to check that the count restarts, so a design that kept the old count would reset the system early. It takes one revert with the policy bit clear and one with it set, after two back-to-back commits, so a design with a one-deep history or swapped history slots would restore the wrong code. Divider pairs that sit on and just outside the ratio bounds are written, so an inclusive/exclusive slip would either take a bad pair or refuse a good one, and a rejected pair that still arms the timer would produce a reset pulse that the scoreboard does not expect.

// File: rtl/wdfr_pkg.sv
package wdfr_pkg;

    localparam int FS_W = 4;
    localparam int WD_W = 4;
    localparam int M_W  = 6;
    localparam int N_W  = 7;

    localparam int M_LO = 20;
    localparam int M_HI = 58;
    localparam int N_LO = 21;
    localparam int N_HI = 125;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
    } div_pair_t;

    typedef enum logic {
        REV_STRAP = 1'b0,
        REV_PRIOR = 1'b1
    } revert_t;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_t;

    function automatic logic div_ok(input logic [M_W-1:0] m, input logic [N_W-1:0] n);
        int mi;
        int ni;
        mi = int'(m);
        ni = int'(n);
        return (mi >= M_LO) && (mi <= M_HI) && (ni >= N_LO) && (ni <= N_HI)
            && (ni > mi) && (2 * mi > ni);
    endfunction

endpackage

// File: rtl/wdfr_div_reg.sv
module wdfr_div_reg
    import wdfr_pkg::*;
#(
    parameter int M_DEFAULT = 30,
    parameter int N_DEFAULT = 45
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr,
    input  logic [M_W-1:0] m_in,
    input  logic [N_W-1:0] n_in,
    input  logic           en,
    output div_pair_t      active,
    output logic           commit
);
    localparam div_pair_t DFLT = '{m: M_W'(M_DEFAULT), n: N_W'(N_DEFAULT)};

    div_pair_t stored;

    assign commit = wr && div_ok(m_in, n_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            stored <= DFLT;
        end else if (commit) begin
            stored <= '{m: m_in, n: n_in};
        end
    end

    assign active = en ? stored : DFLT;
endmodule

// File: rtl/wdfr_timer.sv
module wdfr_timer
    import wdfr_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            arm,
    input  logic            cancel,
    input  logic [WD_W-1:0] period,
    output logic            expire
);
    localparam int MS_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [MS_W-1:0] MS_LAST = MS_W'(TICKS_PER_SEC - 1);

    tmr_state_t      state;
    logic [MS_W-1:0] ms_cnt;
    logic [WD_W-1:0] sec_cnt;
    logic [WD_W:0]   sec_next;
    logic            ms_wrap;

    assign sec_next = {1'b0, sec_cnt} + {{WD_W{1'b0}}, 1'b1};
    assign ms_wrap  = (ms_cnt == MS_LAST);
    assign expire   = (state == TMR_RUN) && tick && !arm && !cancel && ms_wrap
                   && (sec_next >= {1'b0, period});

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            state   <= TMR_IDLE;
            ms_cnt  <= '0;
            sec_cnt <= '0;
        end else if (arm) begin
            state   <= TMR_RUN;
            ms_cnt  <= '0;
            sec_cnt <= '0;
        end else if (state == TMR_RUN && tick) begin
            if (ms_wrap) begin
                ms_cnt <= '0;
                if (expire) begin
                    state   <= TMR_IDLE;
                    sec_cnt <= '0;
                end else begin
                    sec_cnt <= sec_next[WD_W-1:0];
                end
            end else begin
                ms_cnt <= ms_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdfr_pulse.sv
module wdfr_pulse #(
    parameter int RST_TICKS = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic start,
    output logic pulse_n
);
    localparam int PW = $clog2(RST_TICKS + 1);

    logic [PW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (start) begin
            remain <= PW'(RST_TICKS);
        end else if (tick && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign pulse_n = (remain == '0);
endmodule

// File: rtl/wdfr_freq_sel.sv
module wdfr_freq_sel
    import wdfr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [FS_W-1:0] hw_fs,
    input  logic            sw_wr,
    input  logic [FS_W-1:0] sw_code,
    input  logic            expire,
    input  revert_t         policy,
    output logic [FS_W-1:0] active
);
    logic [FS_W-1:0] last_sw;
    logic [FS_W-1:0] prior_sw;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_sw  <= hw_fs;
            prior_sw <= hw_fs;
            active   <= hw_fs;
        end else if (sw_wr) begin
            prior_sw <= last_sw;
            last_sw  <= sw_code;
            active   <= sw_code;
        end else if (expire) begin
            active <= (policy == REV_PRIOR) ? prior_sw : hw_fs;
        end
    end
endmodule

// File: rtl/wdfr_ctrl.sv
module wdfr_ctrl
    import wdfr_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000,
    parameter int RST_TICKS     = 6,
    parameter int M_DEFAULT     = 30,
    parameter int N_DEFAULT     = 45
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_ms,
    input  logic [FS_W-1:0] hw_fs,
    input  logic            sw_fs_wr,
    input  logic [FS_W-1:0] sw_fs_code,
    input  logic            wd_wr,
    input  logic [WD_W-1:0] wd_period,
    input  logic            wd_revert,
    input  logic            div_wr,
    input  logic [M_W-1:0]  div_m,
    input  logic [N_W-1:0]  div_n,
    input  logic            div_en,
    output logic [FS_W-1:0] act_fs,
    output logic [M_W-1:0]  act_m,
    output logic [N_W-1:0]  act_n,
    output logic            wd_timeout,
    output logic            sys_rst_n
);
    logic [WD_W-1:0] period_q;
    revert_t         policy_q;
    logic            div_commit;
    logic            arm;
    logic            cancel;
    logic            expire;
    div_pair_t       div_act;

    assign cancel = wd_wr && (wd_period == '0);
    assign arm    = (sw_fs_wr || div_commit) && (period_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q   <= '0;
            policy_q   <= REV_STRAP;
            wd_timeout <= 1'b0;
        end else begin
            if (wd_wr) begin
                period_q <= wd_period;
                policy_q <= revert_t'(wd_revert);
            end
            if (cancel) begin
                wd_timeout <= 1'b0;
            end else if (expire) begin
                wd_timeout <= 1'b1;
            end
        end
    end

    wdfr_div_reg #(.M_DEFAULT(M_DEFAULT), .N_DEFAULT(N_DEFAULT)) u_div (
        .clk(clk), .rst(rst), .wr(div_wr), .m_in(div_m), .n_in(div_n),
        .en(div_en), .active(div_act), .commit(div_commit)
    );

    wdfr_timer #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_tmr (
        .clk(clk), .rst(rst), .tick(tick_ms), .arm(arm), .cancel(cancel),
        .period(period_q), .expire(expire)
    );

    wdfr_pulse #(.RST_TICKS(RST_TICKS)) u_pulse (
        .clk(clk), .rst(rst), .tick(tick_ms), .start(expire), .pulse_n(sys_rst_n)
    );

    wdfr_freq_sel u_fsel (
        .clk(clk), .rst(rst), .hw_fs(hw_fs), .sw_wr(sw_fs_wr), .sw_code(sw_fs_code),
        .expire(expire), .policy(policy_q), .active(act_fs)
    );

    assign act_m = div_act.m;
    assign act_n = div_act.n;
endmodule

// File: rtl/wdfr_ctrl_chk.sv
module wdfr_ctrl_chk
    import wdfr_pkg::*;
#(
    parameter int M_DEFAULT = 30,
    parameter int N_DEFAULT = 45
) (
    input logic            clk,
    input logic            rst,
    input logic [FS_W-1:0] hw_fs,
    input logic            sw_fs_wr,
    input logic [FS_W-1:0] sw_fs_code,
    input logic            wd_wr,
    input logic [WD_W-1:0] wd_period,
    input logic            div_wr,
    input logic [M_W-1:0]  div_m,
    input logic [N_W-1:0]  div_n,
    input logic            div_en,
    input logic [FS_W-1:0] act_fs,
    input logic [M_W-1:0]  act_m,
    input logic [N_W-1:0]  act_n,
    input logic            wd_timeout,
    input logic            sys_rst_n
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (act_fs == $past(hw_fs)) && !wd_timeout && sys_rst_n);

    // R2
    sw_commit_chk: assert property (@(posedge clk) disable iff (rst)
        sw_fs_wr |=> act_fs == $past(sw_fs_code));

    // R6
    pulse_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst_n) |-> wd_timeout);

    // R6
    flag_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wd_timeout) |-> !sys_rst_n);

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wd_wr && wd_period == '0) |=> !wd_timeout);

    // R10
    div_default_chk: assert property (@(posedge clk) disable iff (rst)
        !div_en |-> (act_m == M_W'(M_DEFAULT)) && (act_n == N_W'(N_DEFAULT)));

    // R11
    div_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (div_wr && div_en && !div_ok(div_m, div_n))
        |=> !div_en || (act_m == $past(act_m) && act_n == $past(act_n)));
endmodule

bind wdfr_ctrl wdfr_ctrl_chk #(.M_DEFAULT(M_DEFAULT), .N_DEFAULT(N_DEFAULT)) u_chk (
    .clk(clk), .rst(rst), .hw_fs(hw_fs), .sw_fs_wr(sw_fs_wr), .sw_fs_code(sw_fs_code),
    .wd_wr(wd_wr), .wd_period(wd_period), .div_wr(div_wr), .div_m(div_m),
    .div_n(div_n), .div_en(div_en), .act_fs(act_fs), .act_m(act_m), .act_n(act_n),
    .wd_timeout(wd_timeout), .sys_rst_n(sys_rst_n)
);

// File: tb/test_wdfr_ctrl.sv
module test_wdfr_ctrl;
    localparam int TPS  = 4;
    localparam int RSTT = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_ms = 1'b0;
    logic [3:0] hw_fs = 4'h7;
    logic       sw_fs_wr = 1'b0;
    logic [3:0] sw_fs_code = '0;
    logic       wd_wr = 1'b0;
    logic [3:0] wd_period = '0;
    logic       wd_revert = 1'b0;
    logic       div_wr = 1'b0;
    logic [5:0] div_m = '0;
    logic [6:0] div_n = '0;
    logic       div_en = 1'b0;
    logic [3:0] act_fs;
    logic [5:0] act_m;
    logic [6:0] act_n;
    logic       wd_timeout;
    logic       sys_rst_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [3:0] fs;
        string      req;
    } exp_pulse_t;

    exp_pulse_t sb[$];

    always #2 clk = ~clk;

    wdfr_ctrl #(.TICKS_PER_SEC(TPS), .RST_TICKS(RSTT), .M_DEFAULT(30), .N_DEFAULT(45)) i_wdfr_ctrl (
        .clk(clk), .rst(rst), .tick_ms(tick_ms), .hw_fs(hw_fs), .sw_fs_wr(sw_fs_wr),
        .sw_fs_code(sw_fs_code), .wd_wr(wd_wr), .wd_period(wd_period), .wd_revert(wd_revert),
        .div_wr(div_wr), .div_m(div_m), .div_n(div_n), .div_en(div_en), .act_fs(act_fs),
        .act_m(act_m), .act_n(act_n), .wd_timeout(wd_timeout), .sys_rst_n(sys_rst_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_ms = 1'b1;
            step();
            tick_ms = 1'b0;
            step();
        end
    endtask

    task automatic sw_commit(input logic [3:0] code);
        sw_fs_wr = 1'b1;
        sw_fs_code = code;
        step();
        sw_fs_wr = 1'b0;
    endtask

    task automatic wd_write(input logic [3:0] p, input logic rv);
        wd_wr = 1'b1;
        wd_period = p;
        wd_revert = rv;
        step();
        wd_wr = 1'b0;
    endtask

    task automatic div_write(input logic [5:0] m, input logic [6:0] n);
        div_wr = 1'b1;
        div_m = m;
        div_n = n;
        step();
        div_wr = 1'b0;
    endtask

    // scoreboard monitor: each reset pulse is compared with the next expected item
    logic       prev_n = 1'b1;
    int         width  = 0;
    logic [3:0] cap_fs = '0;
    logic       cap_to = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_n && !sys_rst_n) begin
                cap_fs = act_fs;
                cap_to = wd_timeout;
                width  = 0;
            end
            if (!sys_rst_n && tick_ms) width++;
            if (!prev_n && sys_rst_n) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R4", 1, 0);
                end else begin
                    exp_pulse_t e;
                    e = sb.pop_front();
                    check(cap_fs == e.fs, e.req, int'(cap_fs), int'(e.fs));
                    check(cap_to == 1'b1, "R6", int'(cap_to), 1);
                    check(width == RSTT, "R6", width, RSTT);
                end
            end
            prev_n = sys_rst_n;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        // R1 reset state
        check(act_fs == 4'h7, "R1", int'(act_fs), 7);
        check(!wd_timeout && sys_rst_n, "R1", int'({wd_timeout, sys_rst_n}), 1);
        check(act_m == 6'd30 && act_n == 7'd45, "R1", int'(act_m), 30);

        // R2 commit, R4 period zero does not arm
        sw_commit(4'h3);
        check(act_fs == 4'h3, "R2", int'(act_fs), 3);
        ticks(40);
        check(sys_rst_n && !wd_timeout, "R4", int'(sys_rst_n), 1);

        // R3 exact period, R6 pulse, R7 strap revert
        wd_write(4'd2, 1'b0);
        sw_commit(4'h5);
        check(act_fs == 4'h5, "R2", int'(act_fs), 5);
        ticks(2 * TPS - 1);
        check(sys_rst_n && !wd_timeout, "R3", int'(sys_rst_n), 1);
        sb.push_back('{fs: 4'h7, req: "R7"});
        ticks(1);
        check(wd_timeout, "R6", int'(wd_timeout), 1);
        check(!sys_rst_n, "R3", int'(sys_rst_n), 0);
        check(act_fs == 4'h7, "R7", int'(act_fs), 7);
        ticks(RSTT - 1);
        check(!sys_rst_n, "R6", int'(sys_rst_n), 0);
        ticks(1);
        check(sys_rst_n, "R6", int'(sys_rst_n), 1);
        check(wd_timeout, "R6", int'(wd_timeout), 1);
        wd_write(4'd0, 1'b0);
        check(!wd_timeout, "R9", int'(wd_timeout), 0);

        // R13 restart, R8 prior software code
        wd_write(4'd1, 1'b1);
        sw_commit(4'h9);
        ticks(TPS - 1);
        sw_commit(4'hA);
        ticks(TPS - 1);
        check(sys_rst_n, "R13", int'(sys_rst_n), 1);
        sb.push_back('{fs: 4'h9, req: "R8"});
        ticks(1);
        check(act_fs == 4'h9, "R8", int'(act_fs), 9);
        ticks(RSTT);
        wd_write(4'd0, 1'b1);

        // R5 cancel before expiry
        wd_write(4'd1, 1'b0);
        sw_commit(4'hC);
        ticks(TPS - 1);
        wd_write(4'd0, 1'b0);
        ticks(10);
        check(sys_rst_n && !wd_timeout, "R5", int'(sys_rst_n), 1);
        check(act_fs == 4'hC, "R5", int'(act_fs), 12);

        // R10 divider acceptance and selection
        div_en = 1'b1;
        div_write(6'd40, 7'd70);
        check(act_m == 6'd40 && act_n == 7'd70, "R10", int'(act_m), 40);
        div_en = 1'b0;
        step();
        check(act_m == 6'd30 && act_n == 7'd45, "R10", int'(act_n), 45);
        div_en = 1'b1;

        // R11 rejected pair: unchanged, no arming
        wd_write(4'd1, 1'b0);
        div_write(6'd20, 7'd45);
        check(act_m == 6'd40 && act_n == 7'd70, "R11", int'(act_m), 40);
        div_write(6'd19, 7'd21);
        check(act_m == 6'd40, "R11", int'(act_m), 40);
        ticks(2 * TPS);
        check(sys_rst_n && !wd_timeout, "R11", int'(sys_rst_n), 1);

        // R12 accepted pair at the ratio edge arms the timer
        div_write(6'd20, 7'd39);
        check(act_m == 6'd20 && act_n == 7'd39, "R10", int'(act_n), 39);
        ticks(TPS - 1);
        check(sys_rst_n, "R12", int'(sys_rst_n), 1);
        sb.push_back('{fs: 4'h7, req: "R12"});
        ticks(1);
        check(!sys_rst_n && wd_timeout, "R12", int'(sys_rst_n), 0);
        ticks(RSTT);
        wd_write(4'd0, 1'b0);
        repeat (4) step();
        check(sb.size() == 0, "R12", sb.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule